// File: doc/BRIEF.md
# Configurable Synchronous Serial Transceiver

This block is a full-duplex synchronous serial shift engine. It can act as the clock master or as a slave. Software writes a character into a one-word transmit holding register. As soon as the shifter is free, the character moves into the shifter. Its bits are then driven on the serial output while bits from the serial input are collected on the opposite clock edge. When the last bit of the character has been taken in, the assembled word is copied to a receive holding register. At that point a receive pulse is raised.

Several settings are programmable: the character length (2 to 16 bits), the bit order, the clock idle level, the clock phase and the master bit rate. Data stays right-aligned in both holding registers whatever the length and order. As master, the block makes its own shift clock from a 16-bit reload value. As slave, it synchronises an external clock and data line and reacts to their edges. Because the transmit side is double-buffered, the next character can be written while the current one is still on the wire. Frames then follow each other with no gap.

Control is a three-state machine. The states are `ST_IDLE` (shifter empty), `ST_ARMED` (slave only: character loaded, waiting for the first external clock edge) and `ST_SHIFT` (edges are being counted).

- `ST_IDLE` to `ST_SHIFT`: a pending character is moved into the shifter in master mode.
- `ST_IDLE` to `ST_ARMED`: the same move happens in slave mode.
- `ST_ARMED` to `ST_SHIFT`: the first external edge is detected.
- `ST_SHIFT` to `ST_SHIFT` (master) or `ST_SHIFT` to `ST_ARMED` (slave): the frame completes while another character is pending.
- `ST_SHIFT` to `ST_IDLE`: the frame completes while nothing is pending.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, `busy`, `tx_irq`, `rx_irq`, `tx_err` and `rx_ovr` are 0, `rx_rdata` is 0 and `sclk_o` equals `cfg_cpol`.
- R2: A character written while the shifter is empty is moved in at the next clock edge. From the cycle after that edge, `busy` is 1 and `tx_irq` is high for exactly one cycle.
- R3: In master mode `sclk_o` starts at `cfg_cpol`, toggles once every R+1 cycles (R = `cfg_reload`, with 0 treated as 1), toggles 2×L times per frame and ends at `cfg_cpol`.
- R4: The character length is L = `cfg_len_m1` + 1 (a value of 0 is treated as 1, so L = 2). After L bits, `rx_rdata` holds the received bits right-aligned with zeros above bit L−1, and `rx_irq` is high for one cycle.
- R5: When a frame completes with no character pending, `busy` falls in the same cycle that `rx_irq` rises. With a character pending, `busy` stays 1 and `tx_irq` pulses in that same cycle.
- R6: With `cfg_msb_first`=0, bit 0 of the character is sent first. With `cfg_msb_first`=1, bit L−1 is sent first. Received bits are placed in the same order. Transmit bits above L−1 are never sent.
- R7: The leading edge is the transition away from `cfg_cpol`. With `cfg_cpha`=0, the output bit is valid before the leading edge, the input is sampled on the leading edge and the output changes on the trailing edge. With `cfg_cpha`=1, the output changes on the leading edge (except for the first bit, which is presented at load) and the input is sampled on the trailing edge.
- R8: In slave mode, `sclk_o` stays at `cfg_cpol`. `busy` and `tx_irq` follow the move into the shifter, and bits shift on edges of `sclk_i` after a two-flop synchroniser. `sdi` passes through the same two-flop delay. The external clock must be no faster than fclk/4.
- R9: A character written during a transfer is held and is shifted immediately after the current frame ends.
- R10: A write while a character is already pending, and not being moved into the shifter in that cycle, overwrites the pending word and sets the sticky `tx_err`.
- R11: A frame that completes while the receive register is unread sets the sticky `rx_ovr`. A pulse on `rx_rd` marks the register as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1 = generate the shift clock, 0 = follow `sclk_i` |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_msb_first | input | 1 | Bit order, 1 = most significant bit first |
| cfg_len_m1 | input | 4 | Character length minus one (0 treated as 1) |
| cfg_reload | input | 16 | Half-period reload R, half period = R+1 cycles |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 16 | Transmit character, right-aligned |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_rdata | output | 16 | Receive character, right-aligned |
| busy | output | 1 | A character is in the shifter |
| tx_irq | output | 1 | One-cycle pulse: transmit register may be reloaded |
| rx_irq | output | 1 | One-cycle pulse: receive register updated |
| tx_err | output | 1 | Sticky: pending character overwritten |
| rx_ovr | output | 1 | Sticky: unread receive character replaced |
| sclk_o | output | 1 | Shift clock driven in master mode |
| sclk_i | input | 1 | External shift clock in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong edge count or a corrupted baud counter shows up in the same cycle as a misplaced `sclk_o` toggle. It also shows as a `busy` fall or `rx_irq` pulse that comes early or late. A shifter that moves at the wrong edge or in the wrong direction puts a wrong bit on `sdo` at the very next sampling point, long before the frame ends. It then also leaves a wrong right-aligned word in `rx_rdata` once the frame completes. Holding-register faults are visible by the end of the following frame: a lost or overwritten pending character, or a missed sticky flag, leaves a wrong `rx_rdata` or a `tx_err`/`rx_ovr` level that differs from the expected value.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } sst_state_e;
endpackage

// File: rtl/sst_baud.sv
module sst_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;

    // A reload of zero would give a one-cycle half period; clamp it to one.
    assign eff  = (reload == '0) ? DIV_W'(1) : reload;
    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == '0) begin
            cnt <= eff;
        end else begin
            cnt <= cnt - DIV_W'(1);
        end
    end

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sst_sync.sv
module sst_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdi_in,
    output logic sclk_edge,
    output logic sdi_s
);
    logic [2:0] ck;
    logic [1:0] dt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck <= '0;
            dt <= '0;
        end else begin
            ck <= {ck[1:0], sclk_in};
            dt <= {dt[0], sdi_in};
        end
    end

    // Data follows the same two-flop path as the clock, so they stay aligned.
    assign sclk_edge = ck[2] ^ ck[1];
    assign sdi_s     = dt[1];
endmodule

// File: rtl/sst_shift.sv
module sst_shift #(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              msb_first,
    input  logic [CNT_W-1:0]  len,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              sample_bit,
    output logic              sdo_bit,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tsr;
    logic [DATA_W-1:0] rsr;
    logic [DATA_W-1:0] rsr_smp;
    logic [DATA_W-1:0] tx_aligned;
    logic [CNT_W-1:0]  pad;

    assign pad = CNT_W'(DATA_W) - len;

    // MSB-first: left-justify so the top bit is always the one on the wire.
    assign tx_aligned = msb_first ? (load_word << pad) : load_word;
    assign sdo_bit    = msb_first ? tsr[DATA_W-1] : tsr[0];

    always_comb begin
        rsr_smp = rsr;
        if (sample_en) begin
            if (msb_first) rsr_smp = {rsr[DATA_W-2:0], sample_bit};
            else           rsr_smp = {sample_bit, rsr[DATA_W-1:1]};
        end
    end

    // Include the bit sampled on the final edge; right-align LSB-first data.
    assign rx_word = msb_first ? rsr_smp : (rsr_smp >> pad);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsr <= '0;
            rsr <= '0;
        end else if (load) begin
            tsr <= tx_aligned;
            rsr <= '0;
        end else begin
            if (shift_en) tsr <= msb_first ? (tsr << 1) : (tsr >> 1);
            rsr <= rsr_smp;
        end
    end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import sst_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_master,
    input  logic                      cfg_cpol,
    input  logic                      cfg_cpha,
    input  logic                      cfg_msb_first,
    input  logic [$clog2(DATA_W)-1:0] cfg_len_m1,
    input  logic [DIV_W-1:0]          cfg_reload,
    input  logic                      tx_wr,
    input  logic [DATA_W-1:0]         tx_wdata,
    input  logic                      rx_rd,
    output logic [DATA_W-1:0]         rx_rdata,
    output logic                      busy,
    output logic                      tx_irq,
    output logic                      rx_irq,
    output logic                      tx_err,
    output logic                      rx_ovr,
    output logic                      sclk_o,
    input  logic                      sclk_i,
    output logic                      sdo,
    input  logic                      sdi
);
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int EDGE_W = $clog2(2 * DATA_W + 1);

    sst_state_e         state, nxt;
    logic [LEN_W-1:0]   m1_eff;
    logic [CNT_W-1:0]   len;
    logic [EDGE_W-1:0]  edge_last;
    logic [EDGE_W-1:0]  ecnt;
    logic               tick, sclk_edge, sdi_s;
    logic               ev, lead, smp, sh, done, load;
    logic               sclk_lvl;
    logic               tx_full, rx_full;
    logic [DATA_W-1:0]  tx_buf, rx_buf, rx_word;
    logic               sdo_bit, sample_bit;
    logic               tx_irq_q, rx_irq_q, tx_err_q, rx_ovr_q;

    assign m1_eff    = (cfg_len_m1 == '0) ? LEN_W'(1) : cfg_len_m1;
    assign len       = CNT_W'(m1_eff) + CNT_W'(1);
    assign edge_last = (EDGE_W'(len) << 1) - EDGE_W'(1);

    sst_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_master && state == ST_SHIFT),
        .reload (cfg_reload),
        .tick   (tick)
    );

    sst_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_i),
        .sdi_in    (sdi),
        .sclk_edge (sclk_edge),
        .sdi_s     (sdi_s)
    );

    // Edge stream: even counts are leading edges, odd counts trailing.
    assign ev         = cfg_master ? tick : (sclk_edge && state != ST_IDLE);
    assign lead       = ~ecnt[0];
    assign smp        = ev && (lead ^ cfg_cpha);
    assign sh         = ev && !(lead ^ cfg_cpha) && (ecnt != '0);
    assign done       = ev && (ecnt == edge_last);
    assign load       = tx_full && (state == ST_IDLE || done);
    assign sample_bit = cfg_master ? sdi : sdi_s;

    sst_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_word  (tx_buf),
        .msb_first  (cfg_msb_first),
        .len        (len),
        .shift_en   (sh),
        .sample_en  (smp),
        .sample_bit (sample_bit),
        .sdo_bit    (sdo_bit),
        .rx_word    (rx_word)
    );

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (load) nxt = cfg_master ? ST_SHIFT : ST_ARMED;
            ST_ARMED: if (ev) nxt = ST_SHIFT;
            ST_SHIFT: if (done) nxt = load ? (cfg_master ? ST_SHIFT : ST_ARMED) : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath, buffers and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt     <= '0;
            sclk_lvl <= 1'b0;
            tx_buf   <= '0;
            tx_full  <= 1'b0;
            rx_buf   <= '0;
            rx_full  <= 1'b0;
            tx_irq_q <= 1'b0;
            rx_irq_q <= 1'b0;
            tx_err_q <= 1'b0;
            rx_ovr_q <= 1'b0;
        end else begin
            if (load)    ecnt <= '0;
            else if (ev) ecnt <= ecnt + EDGE_W'(1);

            if (load)      sclk_lvl <= cfg_cpol;
            else if (tick) sclk_lvl <= ~sclk_lvl;

            if (tx_wr) begin
                tx_buf  <= tx_wdata;
                tx_full <= 1'b1;
                if (tx_full && !load) tx_err_q <= 1'b1;
            end else if (load) begin
                tx_full <= 1'b0;
            end

            if (done) begin
                rx_buf  <= rx_word;
                rx_full <= 1'b1;
                if (rx_full && !rx_rd) rx_ovr_q <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end

            tx_irq_q <= load;
            rx_irq_q <= done;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign tx_irq   = tx_irq_q;
    assign rx_irq   = rx_irq_q;
    assign tx_err   = tx_err_q;
    assign rx_ovr   = rx_ovr_q;
    assign rx_rdata = rx_buf;
    assign sdo      = sdo_bit;
    assign sclk_o   = (cfg_master && state == ST_SHIFT) ? sclk_lvl : cfg_cpol;

    a_r2_busy_rise_with_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tx_irq);
    a_r2_tx_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    a_r5_busy_drop_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_irq);
    a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (ecnt <= edge_last));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> tx_err);
    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |=> rx_ovr);
endmodule

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
    localparam int CLK_P = 10;
    localparam int H     = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_msb_first = 1'b0;
    logic [3:0]  cfg_len_m1 = 4'd7;
    logic [15:0] cfg_reload = 16'd1;
    logic        tx_wr = 1'b0, rx_rd = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic [15:0] rx_rdata;
    logic        busy, tx_irq, rx_irq, tx_err, rx_ovr, sclk_o, sdo;
    logic        sclk_drv = 1'b0, sdi_drv = 1'b0, loop_en = 1'b1;
    logic        sclk_i, sdi;

    int vec = 0, bad = 0, cyc = 0;
    bit model_on = 0, finished = 0;

    assign sclk_i = sclk_drv;
    assign sdi    = loop_en ? sdo : sdi_drv;

    always #(CLK_P/2) clk = ~clk;

    sync_serial_xcvr uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_msb_first(cfg_msb_first), .cfg_len_m1(cfg_len_m1),
        .cfg_reload(cfg_reload), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .busy(busy), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .tx_err(tx_err), .rx_ovr(rx_ovr), .sclk_o(sclk_o), .sclk_i(sclk_i),
        .sdo(sdo), .sdi(sdi)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Behavioural reference model of master mode (pending queue + frame cycle count).
    bit          m_act, m_pend, m_rxfull, m_txirq, m_rxirq, m_err, m_ovr;
    bit          m_cpol, m_cpha, m_msb;
    int          m_cnt, m_len, m_div;
    logic [15:0] m_cur, m_rx;
    logic [15:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n || !model_on) begin
            m_act = 0; m_pend = 0; m_rxfull = 0; m_txirq = 0; m_rxirq = 0;
            m_err = 0; m_ovr = 0; m_cnt = 0; m_cur = '0; m_rx = '0; m_q.delete();
            m_cpol = cfg_cpol;
        end else begin
            bit done;
            done    = 0;
            m_len   = ((cfg_len_m1 == 0) ? 1 : int'(cfg_len_m1)) + 1;
            m_div   = ((cfg_reload == 0) ? 1 : int'(cfg_reload)) + 1;
            m_cpol  = cfg_cpol; m_cpha = cfg_cpha; m_msb = cfg_msb_first;
            m_txirq = 0; m_rxirq = 0;
            if (m_act) begin
                m_cnt++;
                if (m_cnt == 2 * m_len * m_div) done = 1;
            end
            if (done) begin
                m_rx = m_cur & 16'((1 << m_len) - 1);
                m_rxirq = 1;
                if (m_rxfull && !rx_rd) m_ovr = 1;
                m_rxfull = 1;
                m_act = 0;
            end else if (rx_rd) m_rxfull = 0;
            if (m_pend && !m_act) begin
                m_cur = m_q.pop_front(); m_pend = 0;
                m_act = 1; m_cnt = 0; m_txirq = 1;
            end
            if (tx_wr) begin
                if (m_pend) begin m_err = 1; m_q.delete(); end
                m_q.push_back(tx_wdata); m_pend = 1;
            end
        end
    end

    // Compare on every clock, a quarter period after the edge.
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (model_on && rst_n) begin
            logic exp_sclk;
            exp_sclk = m_act ? (m_cpol ^ (((m_cnt / m_div) % 2) == 1)) : m_cpol;
            chk("R5 busy", busy, m_act);
            chk("R2 tx_irq", tx_irq, m_txirq);
            chk("R4 rx_irq", rx_irq, m_rxirq);
            chk("R3 sclk_o", sclk_o, exp_sclk);
            chk("R4 rx_rdata", rx_rdata, m_rx);
            chk("R10 tx_err", tx_err, m_err);
            chk("R11 rx_ovr", rx_ovr, m_ovr);
            if (m_act && ((m_cnt + 1) % m_div == 0)) begin
                int j;
                j = (m_cnt + 1) / m_div;
                if (((j % 2) == 1) == (m_cpha == 0)) begin
                    int i;
                    i = (j - 1) / 2;
                    chk("R6 R7 master sdo bit", sdo, m_msb ? m_cur[m_len-1-i] : m_cur[i]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++; vec++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic write_tx(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_act || m_pend) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_m(input bit pol, input bit pha, input bit msb, input int m1,
                         input int rl, input logic [15:0] w);
        int n;
        n = ((m1 == 0) ? 1 : m1) + 1;
        @(negedge clk);
        cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_msb_first = msb;
        cfg_len_m1 = 4'(m1); cfg_reload = 16'(rl);
        write_tx(w);
        wait_idle();
        chk("R4 right-aligned master word", rx_rdata, w & 16'((1 << n) - 1));
        read_rx();
    endtask

    task automatic run_s(input bit pol, input bit pha, input bit msb, input int m1,
                         input logic [15:0] tw, input logic [15:0] rw);
        int n;
        n = m1 + 1;
        @(negedge clk);
        cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; cfg_msb_first = msb;
        cfg_len_m1 = 4'(m1); sclk_drv = pol; sdi_drv = 1'b0;
        repeat (4) @(negedge clk);
        write_tx(tw);
        @(negedge clk);
        chk("R8 slave busy after move", busy, 1'b1);
        chk("R8 slave sclk_o idle", sclk_o, pol);
        for (int i = 0; i < n; i++) begin
            int bi;
            bi = msb ? (n - 1 - i) : i;
            if (!pha) begin
                sdi_drv = rw[bi];
                repeat (H) @(negedge clk);
                chk("R7 R6 slave sdo bit", sdo, tw[bi]);
                sclk_drv = ~pol;
                repeat (H) @(negedge clk);
                sclk_drv = pol;
            end else begin
                sclk_drv = ~pol;
                sdi_drv = rw[bi];
                repeat (H) @(negedge clk);
                chk("R7 R6 slave sdo bit", sdo, tw[bi]);
                sclk_drv = pol;
                repeat (H) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        chk("R8 slave received word", rx_rdata, rw & 16'((1 << n) - 1));
        chk("R8 slave busy cleared", busy, 1'b0);
        chk("R8 slave sclk_o still idle", sclk_o, pol);
        read_rx();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 tx_irq", tx_irq, 1'b0);
        chk("R1 rx_irq", rx_irq, 1'b0);
        chk("R1 tx_err", tx_err, 1'b0);
        chk("R1 rx_ovr", rx_ovr, 1'b0);
        chk("R1 rx_rdata", rx_rdata, 16'h0);
        chk("R1 sclk_o", sclk_o, cfg_cpol);
        model_on = 1;

        run_m(1'b0, 1'b0, 1'b0, 7, 1, 16'h00A5);
        run_m(1'b1, 1'b1, 1'b1, 15, 2, 16'hBEEF);
        run_m(1'b0, 1'b1, 1'b1, 1, 1, 16'hFFFE);
        run_m(1'b1, 1'b0, 1'b1, 0, 3, 16'hFFFD);
        run_m(1'b0, 1'b0, 1'b1, 11, 0, 16'h7C35);
        run_m(1'b1, 1'b1, 1'b0, 4, 1, 16'h0016);

        // Back-to-back frames, overwrite of a pending word and an unread result.
        @(negedge clk);
        cfg_master = 1'b1; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_msb_first = 1'b0;
        cfg_len_m1 = 4'd4; cfg_reload = 16'd0;
        write_tx(16'h0015);
        repeat (3) @(negedge clk);
        write_tx(16'h000A);
        write_tx(16'h0013);
        chk("R10 tx_err after overwrite", tx_err, 1'b1);
        wait_idle();
        chk("R9 pending word shifted next", rx_rdata, 16'h0013);
        chk("R11 rx_ovr after unread frame", rx_ovr, 1'b1);
        chk("R10 tx_err stays set", tx_err, 1'b1);

        // Slave mode.
        model_on = 0;
        @(negedge clk); rst_n = 1'b0; loop_en = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        run_s(1'b1, 1'b1, 1'b1, 7, 16'h005C, 16'h00A3);
        run_s(1'b0, 1'b0, 1'b0, 11, 16'h09E1, 16'h03B7);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule